// File: doc/BRIEF.md
# Step-Counter Microcode Sequencer

This block produces the control-store address for a microprogrammed machine whose microwords are wide and drive control lines almost directly. Each instruction owns a fixed block of the store. The block's base is the held opcode. Inside that block, a step counter walks the microwords in order, and a latched branch bit picks between two copies of every step. There is no next-address field. The microword only says which condition to sample and whether this cycle is the fetch that ends the instruction.

On a fetch microword, the next opcode is taken in and the step counter returns to zero on the same edge, so the new instruction starts at its first step. On every other cycle, the counter advances by one. The selected condition is latched as the branch bit, so a decision taken in one microcycle appears in the address of the next. A counter that runs past its last step raises a one-cycle overflow flag.

Top module: `usq_seq`

## Requirements
- R1: The address `ctl_addr` is laid out as follows:
  - bits [13:6] hold the held opcode;
  - bits [5:1] hold the step counter;
  - bit [0] holds the latched branch bit.
- R2: A synchronous reset clears the opcode, the step counter, the branch bit and the overflow flag. After reset, the address is 0.
- R3: On a clock without fetch, the step counter rises by one. From 31 it wraps to 0.
- R4: On a clock with `uw_fetch` high, three things happen on the same edge:
  - the opcode takes `op_in`;
  - the step counter goes to 0;
  - the branch bit goes to 0.
- R5: On a clock without fetch, the held opcode does not change.
- R6: On a clock without fetch and with `uw_sel` in 0..6, the branch bit takes `cc_vec[uw_sel]`.
- R7: Select code 7 is a constant true condition. It sets the branch bit to 1 whatever `cc_vec` holds.
- R8: `step_ovf` is high for exactly the cycle that follows a non-fetch clock taken at step 31. In every other cycle, it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uw_sel | input | 3 | Condition select field of the current microword |
| uw_fetch | input | 1 | Fetch field: load opcode and restart steps |
| cc_vec | input | 7 | Condition inputs from the datapath |
| op_in | input | 8 | Opcode of the next instruction, taken on fetch |
| ctl_addr | output | 14 | Control-store address (registered) |
| op_q | output | 8 | Held opcode (registered) |
| step_ovf | output | 1 | Step counter wrapped on the previous edge |

## Verification
All state in this block appears directly in the address, so a wrong opcode, step or branch bit shows in `ctl_addr` one cycle after the faulty edge. A wrong branch bit shows only in bit 0. A skipped or doubled step breaks the step sequence in bits [5:1]. A stray opcode change flips the upper field partway through an instruction. The bench compares every field against its model on every clock, so each such error is caught in the cycle it first appears.

// File: rtl/usq_pkg.sv
package usq_pkg;
  localparam int OP_W   = 8;
  localparam int STEP_W = 5;
  localparam int SEL_W  = 3;
endpackage

// File: rtl/usq_cond_mux.sv
module usq_cond_mux #(
  parameter int SEL_W = 3,
  localparam int NSRC  = 1 << SEL_W,
  localparam int NCOND = NSRC - 1
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [NCOND-1:0] cc,
  output logic             hit
);
  logic [NSRC-1:0] src;

  // the top code is wired to a constant true; the rest map straight to inputs
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i == NCOND) begin : g_true
      assign src[i] = 1'b1;
    end else begin : g_cc
      assign src[i] = cc[i];
    end
  end

  assign hit = src[sel];
endmodule

// File: rtl/usq_step_ctr.sv
module usq_step_ctr #(
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  output logic [STEP_W-1:0] step_q,
  output logic              ovf_q
);
  localparam logic [STEP_W-1:0] LAST = {STEP_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      ovf_q  <= 1'b0;
    end else if (clear) begin
      step_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      step_q <= step_q + 1'b1;
      ovf_q  <= (step_q == LAST);
    end
  end

  // R3: plain advance when neither reset nor clear was applied
  a_r3_step_advance: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clear)) |-> (step_q == $past(step_q) + 1'b1));

  // R8: an overflow cycle always shows a restarted count
  a_r8_ovf_at_zero: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (step_q == '0));
endmodule

// File: rtl/usq_op_reg.sv
module usq_op_reg #(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [OP_W-1:0] d,
  output logic [OP_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // R5: opcode frozen through an instruction
  a_r5_op_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load)) |-> $stable(q));

  // R4: fetch captures the offered opcode
  a_r4_op_load: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load)) |-> (q == $past(d)));
endmodule

// File: rtl/usq_seq.sv
module usq_seq #(
  parameter int OP_W   = usq_pkg::OP_W,
  parameter int STEP_W = usq_pkg::STEP_W,
  parameter int SEL_W  = usq_pkg::SEL_W,
  localparam int NCOND  = (1 << SEL_W) - 1,
  localparam int ADDR_W = OP_W + STEP_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  uw_sel,
  input  logic              uw_fetch,
  input  logic [NCOND-1:0]  cc_vec,
  input  logic [OP_W-1:0]   op_in,
  output logic [ADDR_W-1:0] ctl_addr,
  output logic [OP_W-1:0]   op_q,
  output logic              step_ovf
);
  localparam logic [SEL_W-1:0] TRUE_CODE = {SEL_W{1'b1}};

  logic              cond_hit;
  logic              br_q;
  logic [STEP_W-1:0] step_q;

  usq_cond_mux #(.SEL_W(SEL_W)) u_cmux (
    .sel (uw_sel),
    .cc  (cc_vec),
    .hit (cond_hit)
  );

  usq_step_ctr #(.STEP_W(STEP_W)) u_step (
    .clk    (clk),
    .rst    (rst),
    .clear  (uw_fetch),
    .step_q (step_q),
    .ovf_q  (step_ovf)
  );

  usq_op_reg #(.OP_W(OP_W)) u_op (
    .clk  (clk),
    .rst  (rst),
    .load (uw_fetch),
    .d    (op_in),
    .q    (op_q)
  );

  // branch latch shares its edge with the step counter
  always_ff @(posedge clk) begin
    if (rst)           br_q <= 1'b0;
    else if (uw_fetch) br_q <= 1'b0;
    else               br_q <= cond_hit;
  end

  // all fields come straight from registers
  assign ctl_addr = {op_q, step_q, br_q};

  // R7: constant-true code always lands in the taken copy
  a_r7_true_code: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(uw_fetch) && $past(uw_sel) == TRUE_CODE) |-> br_q);

  // R4: new instruction enters at step 0, not-taken copy
  a_r4_fetch_entry: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(uw_fetch)) |-> (ctl_addr[STEP_W:0] == '0));

  // R2: first address after reset is zero
  a_r2_reset_zero: assert property (@(posedge clk)
    $past(rst) |-> (ctl_addr == '0 && !step_ovf));
endmodule

// File: tb/usq_seq_tb.sv
module usq_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] uw_sel = '0;
  logic       uw_fetch = 1'b0;
  logic [6:0] cc_vec = '0;
  logic [7:0] op_in = '0;
  logic [13:0] ctl_addr;
  logic [7:0]  op_q;
  logic        step_ovf;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_op = 0, m_step = 0, m_br = 0, m_ovf = 0;

  always #5 clk = ~clk;

  usq_seq u_dut (
    .clk(clk), .rst(rst), .uw_sel(uw_sel), .uw_fetch(uw_fetch),
    .cc_vec(cc_vec), .op_in(op_in),
    .ctl_addr(ctl_addr), .op_q(op_q), .step_ovf(step_ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 addr", int'(ctl_addr), m_op * 64 + m_step * 2 + m_br);
    chk("R5 opcode", int'(op_q), m_op);
    chk("R3 step", int'(ctl_addr[5:1]), m_step);
    chk("R6 branch", int'(ctl_addr[0]), m_br);
    chk("R8 ovf", int'(step_ovf), m_ovf);
  endtask

  task automatic cyc(input bit r, input bit f, input int sel, input int cc, input int op);
    @(negedge clk);
    rst = r; uw_fetch = f; uw_sel = 3'(sel); cc_vec = 7'(cc); op_in = 8'(op);
    @(posedge clk);
    if (r) begin
      m_op = 0; m_step = 0; m_br = 0; m_ovf = 0;
    end else if (f) begin
      m_op = op; m_step = 0; m_br = 0; m_ovf = 0;
    end else begin
      m_ovf = (m_step == 31) ? 1 : 0;
      m_step = (m_step + 1) % 32;
      m_br = (sel == 7) ? 1 : ((cc >> sel) & 1);
    end
    #2;
    compare_all();
  endtask

  initial begin
    // R2: reset state
    cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 5, 127, 200);
    chk("R2 reset addr", int'(ctl_addr), 0);
    // R4: fetch entry
    cyc(0, 1, 3, 127, 8'hA5);
    chk("R4 entry", int'(ctl_addr), 8'hA5 * 64);
    // R6: each real condition, both polarities
    for (int s = 0; s < 7; s++) begin
      cyc(0, 0, s, 1 << s, 0);
      cyc(0, 0, s, 127 ^ (1 << s), 0);
    end
    // R7: constant true with all conditions low
    cyc(0, 0, 7, 0, 0);
    chk("R7 true code", int'(ctl_addr[0]), 1);
    // R3/R8: run through a wrap
    cyc(0, 1, 0, 0, 8'h3C);
    for (int i = 0; i < 40; i++) cyc(0, 0, i % 8, i * 13, 99);
    // R8: fetch at step 31 gives no overflow
    cyc(0, 1, 0, 0, 8'h11);
    for (int i = 0; i < 31; i++) cyc(0, 0, 2, 4, 0);
    cyc(0, 1, 0, 0, 8'h22);
    chk("R8 no ovf on fetch", int'(step_ovf), 0);
    // mixed traffic
    for (int i = 0; i < 300; i++)
      cyc((i % 97) == 50, (i % 11) == 0, (i * 7) % 8, (i * 37) % 128, (i * 29) % 256);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule